// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply Engine

The engine computes C = A × B for square N×N matrices of 16-bit signed integers held in an external word-addressed memory. The output is built one TILE×TILE square at a time. For each output square the engine walks the shared (K) dimension in steps of TILE. At each step it stages one square of A and one square of B into local buffers, then runs one multiply-accumulate per cycle over the staged squares. Each finished output square is written back as 40-bit signed words.

Staging and computing never overlap. A step first fills both buffers completely. It then runs every product over them, and only after that may the next step overwrite them. Buffer positions that fall beyond row or column N−1 are filled with zero and are never fetched from memory. This gives exact results for any N from 1 up to NMAX.

Both memory channels are valid/ready. A read request is held, with a stable address, until ready is seen. The read word arrives on `mem_rd_data` exactly one cycle after the request is accepted, and it cannot be stalled. A write is held, with stable address and data, until ready is seen. A run begins with a one-cycle `start` pulse carrying N and three base addresses. A one-cycle `done` pulse ends the run.

Top module: `tile_matmul_engine`

## Requirements
- R1: Matrices are stored row-major, so element (i,j) of a matrix lies at its base address + i·N + j. For every i,j < N the word written to base_c + i·N + j equals the sum over k < N of A(i,k)·B(k,j), with 16-bit signed operands and a 40-bit signed two's-complement result.
- R2: Buffer positions whose global row or column index is ≥ N hold zero and cause no read request. No address outside the N×N regions of A and B is ever read.
- R3: During one run, each element of A and each element of B is read exactly ceil(N/TILE) times.
- R4: Multiply-accumulate over a step starts only after every position of both staged squares has been written. No buffer position is written while multiply-accumulate is running.
- R5: Every in-range element of C is written exactly once. No write is issued to an address outside the N×N region of C.
- R6: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` stays unchanged in the next cycle.
- R7: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold in the next cycle.
- R8: `done` is high for exactly one cycle per run. When the last element of C is in range, `done` rises in the cycle right after that element's write is accepted.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The current run finishes with its original N and base addresses.
- R10: After reset, `mem_rd_valid`, `mem_wr_valid` and `done` are low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request, taken only when idle |
| n_dim | input | $clog2(NMAX+1) | Matrix dimension N, sampled with start |
| base_a | input | AW | Word address of A(0,0) |
| base_b | input | AW | Word address of B(0,0) |
| base_c | input | AW | Word address of C(0,0) |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | AW | Read word address |
| mem_rd_data | input | DW | Read word, valid one cycle after acceptance |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Memory accepts the write request |
| mem_wr_addr | output | AW | Write word address |
| mem_wr_data | output | ACCW | Output word written to C |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
N is swept over every value from 1 to 9, plus 16. This covers a single partial square, exact multiples of the tile, and sizes just past a multiple, and it separates correct zero fill from stale buffer contents. Operand patterns include small mixed-sign values, full-scale ±32767/−32768 products that exercise the 40-bit accumulation, and an identity B that exposes any transposition or index swap. The memory model applies random back-pressure on both channels, with one run at full readiness. It counts reads and writes per address, which catches re-fetching, fetching of zero-filled positions and duplicate writes. One run sends a second start mid-run with different parameters to show that it is ignored.

// File: rtl/tmm_pkg.sv
package tmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_MAC   = 2'd2,
    ST_WRITE = 2'd3
  } tmm_state_e;
endpackage

// File: rtl/tmm_stage_buf.sv
module tmm_stage_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [IW-1:0]        raddr,
  output logic signed [DW-1:0] rdata
);
  logic signed [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/tmm_acc_bank.sv
module tmm_acc_bank #(
  parameter int DW    = 16,
  parameter int ACCW  = 40,
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   mac_en,
  input  logic [IW-1:0]          mac_idx,
  input  logic signed [DW-1:0]   op_a,
  input  logic signed [DW-1:0]   op_b,
  input  logic [IW-1:0]          rd_idx,
  output logic signed [ACCW-1:0] rd_data
);
  localparam int PW = 2 * DW;

  logic signed [ACCW-1:0] acc_q [DEPTH];
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext;

  assign prod     = op_a * op_b;
  assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) acc_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) acc_q[i] <= '0;
    end else if (mac_en) begin
      acc_q[mac_idx] <= acc_q[mac_idx] + prod_ext;
    end
  end

  assign rd_data = acc_q[rd_idx];

  // R4
  clr_mac_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && mac_en));
endmodule

// File: rtl/tile_matmul_engine.sv
module tile_matmul_engine #(
  parameter int TILE = 4,
  parameter int NMAX = 16,
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int ACCW = 40,
  parameter int NW   = $clog2(NMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NW-1:0]   n_dim,
  input  logic [AW-1:0]   base_a,
  input  logic [AW-1:0]   base_b,
  input  logic [AW-1:0]   base_c,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic [DW-1:0]   mem_rd_data,
  output logic            mem_wr_valid,
  input  logic            mem_wr_ready,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [ACCW-1:0] mem_wr_data,
  output logic            done
);
  import tmm_pkg::*;

  localparam int TB = $clog2(TILE);
  localparam int TT = TILE * TILE;
  localparam int EW = $clog2(TT);
  localparam int GW = NW + TB;
  localparam int MW = 3 * TB;
  localparam logic [EW+1:0] LD_END = (EW+2)'(2 * TT);

  tmm_state_e      state_q;
  logic [NW-1:0]   n_q, nt_q, tr_q, tc_q, kt_q;
  logic [AW-1:0]   ba_q, bb_q, bc_q;
  logic [EW+1:0]   ld_idx_q;
  logic            pend_q;
  logic [EW:0]     pend_idx_q;
  logic [MW-1:0]   mac_q;
  logic [EW-1:0]   wr_idx_q;
  logic            done_q;

  // ---------------- staging (load) address generation ----------------
  logic            ld_sel_b, ld_active, ld_in_rng, ld_adv;
  logic [TB-1:0]   ld_lr, ld_lc;
  logic [GW-1:0]   ld_gi, ld_gj;
  logic [AW-1:0]   ld_off;

  assign ld_sel_b  = ld_idx_q[EW];
  assign ld_lr     = ld_idx_q[EW-1:TB];
  assign ld_lc     = ld_idx_q[TB-1:0];
  assign ld_gi     = ld_sel_b ? {kt_q, ld_lr} : {tr_q, ld_lr};
  assign ld_gj     = ld_sel_b ? {tc_q, ld_lc} : {kt_q, ld_lc};
  assign ld_in_rng = (ld_gi < GW'(n_q)) && (ld_gj < GW'(n_q));
  assign ld_off    = AW'(ld_gi) * AW'(n_q) + AW'(ld_gj);
  assign ld_active = (state_q == ST_LOAD) && (ld_idx_q != LD_END);
  assign ld_adv    = ld_active && (ld_in_rng ? mem_rd_ready : !pend_q);

  assign mem_rd_valid = ld_active && ld_in_rng;
  assign mem_rd_addr  = (ld_sel_b ? bb_q : ba_q) + ld_off;

  // Single write port per buffer: a returning word has priority over zero fill.
  logic            buf_we;
  logic [EW:0]     buf_widx;
  logic [DW-1:0]   buf_wdata;
  logic            we_a, we_b;

  assign buf_we    = pend_q || (ld_active && !ld_in_rng);
  assign buf_widx  = pend_q ? pend_idx_q : ld_idx_q[EW:0];
  assign buf_wdata = pend_q ? mem_rd_data : '0;
  assign we_a      = buf_we && !buf_widx[EW];
  assign we_b      = buf_we &&  buf_widx[EW];

  // ---------------- multiply-accumulate sequencing ----------------
  logic [TB-1:0]          mr, mc, mk;
  logic signed [DW-1:0]   a_rd, b_rd;
  logic                   mac_en, acc_clr;
  logic signed [ACCW-1:0] acc_rd;

  assign mr     = mac_q[MW-1:2*TB];
  assign mc     = mac_q[2*TB-1:TB];
  assign mk     = mac_q[TB-1:0];
  assign mac_en = (state_q == ST_MAC);

  tmm_stage_buf #(.DW(DW), .DEPTH(TT)) u_buf_a (
    .clk(clk), .we(we_a), .waddr(buf_widx[EW-1:0]), .wdata(buf_wdata),
    .raddr({mr, mk}), .rdata(a_rd)
  );

  tmm_stage_buf #(.DW(DW), .DEPTH(TT)) u_buf_b (
    .clk(clk), .we(we_b), .waddr(buf_widx[EW-1:0]), .wdata(buf_wdata),
    .raddr({mk, mc}), .rdata(b_rd)
  );

  // ---------------- write-back ----------------
  logic [GW-1:0] wr_gi, wr_gj;
  logic          wr_in_rng, wr_adv, wr_last;

  assign wr_gi     = {tr_q, wr_idx_q[EW-1:TB]};
  assign wr_gj     = {tc_q, wr_idx_q[TB-1:0]};
  assign wr_in_rng = (wr_gi < GW'(n_q)) && (wr_gj < GW'(n_q));
  assign wr_adv    = (state_q == ST_WRITE) && (wr_in_rng ? mem_wr_ready : 1'b1);
  assign wr_last   = wr_adv && (&wr_idx_q);

  assign mem_wr_valid = (state_q == ST_WRITE) && wr_in_rng;
  assign mem_wr_addr  = bc_q + AW'(wr_gi) * AW'(n_q) + AW'(wr_gj);
  assign mem_wr_data  = acc_rd;

  assign acc_clr = ((state_q == ST_IDLE) && start) || wr_last;

  tmm_acc_bank #(.DW(DW), .ACCW(ACCW), .DEPTH(TT)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .mac_en(mac_en),
    .mac_idx({mr, mc}), .op_a(a_rd), .op_b(b_rd),
    .rd_idx(wr_idx_q), .rd_data(acc_rd)
  );

  // ---------------- control ----------------
  logic [NW:0] nt_calc;
  assign nt_calc = ({1'b0, n_dim} + (NW+1)'(TILE - 1)) >> TB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      n_q        <= '0;
      nt_q       <= '0;
      tr_q       <= '0;
      tc_q       <= '0;
      kt_q       <= '0;
      ba_q       <= '0;
      bb_q       <= '0;
      bc_q       <= '0;
      ld_idx_q   <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      mac_q      <= '0;
      wr_idx_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pend_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            n_q      <= n_dim;
            nt_q     <= nt_calc[NW-1:0];
            ba_q     <= base_a;
            bb_q     <= base_b;
            bc_q     <= base_c;
            tr_q     <= '0;
            tc_q     <= '0;
            kt_q     <= '0;
            ld_idx_q <= '0;
            if (n_dim == '0) done_q  <= 1'b1;
            else             state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (ld_active) begin
            if (ld_in_rng && mem_rd_ready) begin
              pend_q     <= 1'b1;
              pend_idx_q <= ld_idx_q[EW:0];
            end
            if (ld_adv) ld_idx_q <= ld_idx_q + 1'b1;
          end else if (!pend_q) begin
            state_q <= ST_MAC;
            mac_q   <= '0;
          end
        end
        ST_MAC: begin
          mac_q <= mac_q + 1'b1;
          if (&mac_q) begin
            if (kt_q == nt_q - NW'(1)) begin
              state_q  <= ST_WRITE;
              wr_idx_q <= '0;
            end else begin
              kt_q     <= kt_q + 1'b1;
              ld_idx_q <= '0;
              state_q  <= ST_LOAD;
            end
          end
        end
        ST_WRITE: begin
          if (wr_adv) begin
            wr_idx_q <= wr_idx_q + 1'b1;
            if (&wr_idx_q) begin
              kt_q     <= '0;
              ld_idx_q <= '0;
              if (tc_q == nt_q - NW'(1)) begin
                tc_q <= '0;
                if (tr_q == nt_q - NW'(1)) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                end else begin
                  tr_q    <= tr_q + 1'b1;
                  state_q <= ST_LOAD;
                end
              end else begin
                tc_q    <= tc_q + 1'b1;
                state_q <= ST_LOAD;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done = done_q;

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R4
  no_stage_write_in_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MAC) |-> !(we_a || we_b));

  // R4
  load_drained_before_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && !mem_rd_valid && pend_q) |=> (state_q != ST_MAC));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R9
  busy_param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(n_q) && $stable(bc_q) && $stable(ba_q)));

  // R2
  zero_fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_active && !ld_in_rng) |-> !mem_rd_valid);
endmodule

// File: tb/tile_matmul_engine_tb.sv
module tile_matmul_engine_tb;
  localparam int TILE = 4, NMAX = 16, AW = 16, DW = 16, ACCW = 40;
  localparam int NW = $clog2(NMAX + 1);
  localparam int BA = 0, BB = 300, BC = 600;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NW-1:0]   n_dim = '0;
  logic [AW-1:0]   base_a = '0, base_b = '0, base_c = '0;
  logic            mem_rd_valid, mem_rd_ready;
  logic [AW-1:0]   mem_rd_addr;
  logic [DW-1:0]   mem_rd_data = '0;
  logic            mem_wr_valid, mem_wr_ready;
  logic [AW-1:0]   mem_wr_addr;
  logic [ACCW-1:0] mem_wr_data;
  logic            done;

  tile_matmul_engine #(.TILE(TILE), .NMAX(NMAX), .AW(AW), .DW(DW), .ACCW(ACCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_dim(n_dim),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .done(done)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, pc = 0;
  logic [15:0] mem [0:1023];
  int rcnt [0:1023];
  int wcnt [0:1023];
  logic [39:0] wval [0:1023];
  int stray_w = 0, hold_err = 0, done_cnt = 0, cur_n = 0;
  int last_w_cyc = 0, done_cyc = 0;
  longint expc [0:15][0:15];
  logic [7:0] lf = 8'h5a;
  bit full_ready = 1'b0;
  logic prv_rv = 1'b0, prv_rr = 1'b0, prv_wv = 1'b0, prv_wr = 1'b0;
  logic [AW-1:0] prv_ra = '0, prv_wa = '0;
  logic [ACCW-1:0] prv_wd = '0;

  // back-pressure source, changed away from the active edge
  always @(negedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  assign mem_rd_ready = full_ready | lf[0] | lf[1];
  assign mem_wr_ready = full_ready | lf[2] | lf[6];

  // memory model and monitor
  always @(posedge clk) begin
    pc <= pc + 1;
    if (rst_n) begin
      if (mem_rd_valid && mem_rd_ready) begin
        mem_rd_data <= mem[mem_rd_addr[9:0]];
        rcnt[mem_rd_addr[9:0]] <= rcnt[mem_rd_addr[9:0]] + 1;
      end
      if (mem_wr_valid && mem_wr_ready) begin
        if (int'(mem_wr_addr) < BC || int'(mem_wr_addr) >= BC + cur_n * cur_n)
          stray_w <= stray_w + 1;
        else begin
          wcnt[mem_wr_addr[9:0]] <= wcnt[mem_wr_addr[9:0]] + 1;
          wval[mem_wr_addr[9:0]] <= mem_wr_data;
        end
        last_w_cyc <= pc;
      end
      if (prv_rv && !prv_rr && (!mem_rd_valid || mem_rd_addr != prv_ra)) hold_err <= hold_err + 1;
      if (prv_wv && !prv_wr && (!mem_wr_valid || mem_wr_addr != prv_wa || mem_wr_data != prv_wd))
        hold_err <= hold_err + 1;
      if (done) begin
        done_cnt <= done_cnt + 1;
        done_cyc <= pc;
      end
    end
    prv_rv <= mem_rd_valid; prv_rr <= mem_rd_ready; prv_ra <= mem_rd_addr;
    prv_wv <= mem_wr_valid; prv_wr <= mem_wr_ready; prv_wa <= mem_wr_addr; prv_wd <= mem_wr_data;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] aval(int pat, int n, int i, int j);
    if (pat == 1) return ((i + j) % 2 == 1) ? -16'sd32768 : 16'sd32767;
    return 16'(((i * 5 + j * 3 + n) % 19) - 9);
  endfunction

  function automatic logic signed [15:0] bval(int pat, int i, int j);
    if (pat == 1) return ((i * 3 + j) % 3 == 0) ? -16'sd32768 : 16'sd32767;
    if (pat == 2) return (i == j) ? 16'sd1 : 16'sd0;
    return 16'(((i * 2 + j * 7) % 13) - 6);
  endfunction

  task automatic run(input int n, input int pat, input bit poke);
    int reps, bad, t;
    reps = (n + TILE - 1) / TILE;
    for (int a = 0; a < 1024; a++) begin
      mem[a] = 16'h7000 + 16'(a);
      rcnt[a] = 0; wcnt[a] = 0; wval[a] = '0;
    end
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++) begin
        mem[BA + i * n + j] = aval(pat, n, i, j);
        mem[BB + i * n + j] = bval(pat, i, j);
      end
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++) begin
        expc[i][j] = 0;
        for (int k = 0; k < n; k++)
          expc[i][j] += longint'(aval(pat, n, i, k)) * longint'(bval(pat, k, j));
      end
    stray_w = 0; hold_err = 0; done_cnt = 0; cur_n = n;
    @(negedge clk);
    start = 1'b1; n_dim = NW'(n);
    base_a = AW'(BA); base_b = AW'(BB); base_c = AW'(BC);
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 40000) begin
      @(negedge clk);
      t++;
      if (poke && t == 40) begin
        start = 1'b1; n_dim = NW'(2);
        base_a = 16'd700; base_b = 16'd800; base_c = 16'd900;
      end
      if (poke && t == 41) start = 1'b0;
    end
    repeat (6) @(negedge clk);
    // R1 R4: every in-range product word, exact
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        chk(longint'($signed(wval[BC + i * n + j])) == expc[i][j], "R1",
            $sformatf("N=%0d C(%0d,%0d)", n, i, j),
            longint'($signed(wval[BC + i * n + j])), expc[i][j]);
    // R5: each output element written once, nothing outside C
    bad = 0;
    for (int a = 0; a < n * n; a++) if (wcnt[BC + a] != 1) bad++;
    chk(bad == 0, "R5", $sformatf("N=%0d elements not written once", n), bad, 0);
    chk(stray_w == 0, "R5", $sformatf("N=%0d stray writes", n), stray_w, 0);
    // R3: read count per A/B element
    bad = 0;
    for (int a = 0; a < n * n; a++) begin
      if (rcnt[BA + a] != reps) bad++;
      if (rcnt[BB + a] != reps) bad++;
    end
    chk(bad == 0, "R3", $sformatf("N=%0d elements read != %0d times", n, reps), bad, 0);
    // R2: zero-filled positions never fetched, nothing outside A/B read
    bad = 0;
    for (int a = 0; a < 1024; a++)
      if (!((a >= BA && a < BA + n * n) || (a >= BB && a < BB + n * n)) && rcnt[a] != 0) bad++;
    chk(bad == 0, "R2", $sformatf("N=%0d reads outside A/B", n), bad, 0);
    // R6 R7
    chk(hold_err == 0, "R6/R7", $sformatf("N=%0d request changed under back-pressure", n), hold_err, 0);
    // R8
    chk(done_cnt == 1, "R8", $sformatf("N=%0d done pulses", n), done_cnt, 1);
    if (n % TILE == 0)
      chk(done_cyc - last_w_cyc == 1, "R8", $sformatf("N=%0d done delay after final write", n),
          done_cyc - last_w_cyc, 1);
    if (poke)
      chk(done_cnt == 1 && stray_w == 0 && rcnt[700] == 0, "R9",
          "start while busy changed the run", stray_w + rcnt[700], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: idle outputs after reset
    chk(!mem_rd_valid, "R10", "rd_valid in reset", longint'(mem_rd_valid), 0);
    chk(!mem_wr_valid, "R10", "wr_valid in reset", longint'(mem_wr_valid), 0);
    chk(!done, "R10", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_rd_valid && !mem_wr_valid && !done, "R10", "outputs idle after reset", 0, 0);
    for (int n = 1; n <= 9; n++) run(n, n % 3, n == 5);
    full_ready = 1'b1;
    run(4, 0, 1'b0);
    full_ready = 1'b0;
    run(8, 2, 1'b0);
    run(16, 1, 1'b0);
    summary();
    $finish;
  end
endmodule